// File: doc/BRIEF.md
# Multi-Mode Timer Counter

This block is the counting core of a general-purpose timer. A count register of parameterised width moves forward only on cycles where a tick enable is high. That tick comes from one of four sources and then passes through a prescaler. A two-bit mode field chooses the counting pattern: held still, repeating up to a programmable period, free-running over the full range, or rising to the period and falling back to zero.

Each time the count returns to zero, a sticky overflow flag is raised. An enable bit routes that flag to an interrupt request. Two strobes tell the compare channels next to the block when the count equals zero and when it equals the period. A count-direction output lets those channels tell the rising half of an up/down cycle from the falling half. A one-cycle clear pulse restarts the count, the direction and the prescaler all at once.

Top module: `modal_timer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the count is 0, the direction output is 0 (up), and the flag and interrupt request are 0.
- R2: With mode 00 the count holds its value whatever ticks arrive.
- R3: With mode 01, each advance adds one while the count is below the period. An advance at or above the period loads 0 and sets the flag.
- R4: With mode 10, each advance adds one. An advance at the all-ones value loads 0 and sets the flag.
- R5: With mode 11, the count rises by one per advance while it is below the period. An advance at or above the period makes it fall by one per advance, with the direction output at 1 while it falls. The advance that lands on 0 sets the flag and returns the direction to 0. With period 0 the count stays at 0 and every advance sets the flag.
- R6: The divider field 00/01/10/11 makes the counter advance on every 1st/2nd/4th/8th selected tick. The first advance after reset or clear falls on the last tick of the first group.
- R7: The source field picks the tick as follows: 00 the external tick, 01 internal tick A, 10 internal tick B, 11 the inverted external tick.
- R8: A clear pulse sets the count to 0, the direction to up and the prescaler to its start in the next cycle. It overrides any advance in that cycle and does not set the flag.
- R9: The flag stays set until a flag-clear pulse. A zero-return in the same cycle as a flag-clear leaves it set.
- R10: The interrupt request is high exactly when the flag is set and the interrupt enable is 1.
- R11: The zero strobe is high whenever the count is 0. The period strobe is high whenever the count equals the period input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Counting mode: 00 halt, 01 up to period, 10 free-running, 11 up/down |
| div_i | input | 2 | Prescaler: 00 /1, 01 /2, 10 /4, 11 /8 |
| src_i | input | 2 | Tick source select |
| clr_i | input | 1 | One-cycle clear pulse |
| period_i | input | CNT_W | Period value for modes 01 and 11 |
| ext_tick_i | input | 1 | External tick enable |
| int_a_tick_i | input | 1 | Internal tick enable A |
| int_b_tick_i | input | 1 | Internal tick enable B |
| ie_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | One-cycle flag clear pulse |
| count_o | output | CNT_W | Current count |
| down_o | output | 1 | 1 while counting down |
| period_hit_o | output | 1 | Count equals period |
| zero_hit_o | output | 1 | Count equals zero |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 6-bit count. This brings the free-running wrap at 63 and the whole range of period values within a few dozen advances. The bench sweeps all sixteen source and divider pairs against pseudo-random tick patterns. It runs every period from 0 to 7 in both the period mode and the up/down mode, including the turnaround corner cases at periods 0 and 1. An arithmetic model of the requirements predicts every output on every cycle, across halt phases, clear pulses landing on advances, and flag clears racing zero-returns.

// File: rtl/modal_timer_pkg.sv
package modal_timer_pkg;

   typedef enum logic [1:0] {
      MODE_HALT = 2'b00,
      MODE_UP   = 2'b01,
      MODE_FREE = 2'b10,
      MODE_UPDN = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      SRC_EXT     = 2'b00,
      SRC_INT_A   = 2'b01,
      SRC_INT_B   = 2'b10,
      SRC_EXT_INV = 2'b11
   } tick_src_e;

   localparam int NUM_SRC = 4;

endpackage

// File: rtl/timer_tick_gate.sv
module timer_tick_gate
   import modal_timer_pkg::*;
#(
   parameter int DIV_BITS = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                clr_i,
   input  tick_src_e           src_i,
   input  logic [DIV_BITS-1:0] div_i,
   input  logic                ext_tick_i,
   input  logic                int_a_tick_i,
   input  logic                int_b_tick_i,
   output logic                adv_o
);

   localparam int PRE_W = (1 << DIV_BITS) - 1;

   if (DIV_BITS < 1 || DIV_BITS > 3) begin : g_bad_div
      $error("timer_tick_gate: DIV_BITS must lie in 1..3");
   end

   logic [NUM_SRC-1:0] src_vec;
   logic               src_tick;
   logic [PRE_W-1:0]   pre_q;
   logic [PRE_W-1:0]   mask;

   assign src_vec  = {~ext_tick_i, int_b_tick_i, int_a_tick_i, ext_tick_i};
   assign src_tick = src_vec[src_i];
   assign mask     = PRE_W'((1 << div_i) - 1);
   assign adv_o    = src_tick && ((pre_q & mask) == mask);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pre_q <= '0;
      end else if (clr_i) begin
         pre_q <= '0;
      end else if (src_tick) begin
         pre_q <= pre_q + 1'b1;
      end
   end

   // R8: clear restarts the prescaler
   assert_pre_restart_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> pre_q == '0);

   // R6: without a source tick there is no advance and the prescaler keeps its phase
   assert_pre_idle_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!src_tick && !clr_i) |=> pre_q == $past(pre_q));

endmodule

// File: rtl/timer_count_core.sv
module timer_count_core
   import modal_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             adv_i,
   input  cnt_mode_e        mode_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic             down_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             down_q, down_d;
   logic             wrap;

   always_comb begin
      cnt_d  = cnt_q;
      down_d = down_q;
      wrap   = 1'b0;
      if (clr_i) begin
         cnt_d  = '0;
         down_d = 1'b0;
      end else if (adv_i) begin
         unique case (mode_i)
            MODE_HALT: ;
            MODE_UP: begin
               if (cnt_q >= period_i) begin
                  cnt_d = '0;
                  wrap  = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
            MODE_FREE: begin
               cnt_d = cnt_q + 1'b1;
               wrap  = (cnt_q == CNT_MAX);
            end
            MODE_UPDN: begin
               if (!down_q && cnt_q < period_i) begin
                  cnt_d = cnt_q + 1'b1;
               end else if (cnt_q == '0) begin
                  down_d = 1'b0;
                  wrap   = 1'b1;
               end else begin
                  cnt_d = cnt_q - 1'b1;
                  if (cnt_q == CNT_ONE) begin
                     down_d = 1'b0;
                     wrap   = 1'b1;
                  end else begin
                     down_d = 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         down_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         down_q <= down_d;
      end
   end

   assign count_o = cnt_q;
   assign down_o  = down_q;
   assign wrap_o  = wrap;

   assert_halt_hold_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MODE_HALT && !clr_i) |=> cnt_q == $past(cnt_q));

   assert_up_step_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clr_i && mode_i == MODE_UP && cnt_q < period_i)
      |=> cnt_q == $past(cnt_q) + 1'b1);

   assert_free_wrap_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clr_i && mode_i == MODE_FREE && cnt_q == CNT_MAX) |=> cnt_q == '0);

   assert_updn_turn_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (adv_i && !clr_i && mode_i == MODE_UPDN && !down_q && cnt_q >= period_i
       && cnt_q > CNT_ONE) |=> down_q);

   assert_clear_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0 && !down_q));

endmodule

// File: rtl/timer_ovf_flag.sv
module timer_ovf_flag (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= 1'b0;
      end else if (set_i) begin
         flag_q <= 1'b1;
      end else if (clr_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

   assert_flag_set_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i |=> flag_q);

   assert_flag_sticky_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q && !clr_i) |=> flag_q);

endmodule

// File: rtl/modal_timer.sv
module modal_timer
   import modal_timer_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int DIV_BITS = 2
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [1:0]          mode_i,
   input  logic [DIV_BITS-1:0] div_i,
   input  logic [1:0]          src_i,
   input  logic                clr_i,
   input  logic [CNT_W-1:0]    period_i,
   input  logic                ext_tick_i,
   input  logic                int_a_tick_i,
   input  logic                int_b_tick_i,
   input  logic                ie_i,
   input  logic                flag_clr_i,
   output logic [CNT_W-1:0]    count_o,
   output logic                down_o,
   output logic                period_hit_o,
   output logic                zero_hit_o,
   output logic                flag_o,
   output logic                irq_o
);

   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("modal_timer: CNT_W must lie in 2..32");
   end

   logic adv;
   logic wrap;

   timer_tick_gate #(.DIV_BITS(DIV_BITS)) u_tick (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr_i),
      .src_i        (tick_src_e'(src_i)),
      .div_i        (div_i),
      .ext_tick_i   (ext_tick_i),
      .int_a_tick_i (int_a_tick_i),
      .int_b_tick_i (int_b_tick_i),
      .adv_o        (adv)
   );

   timer_count_core #(.CNT_W(CNT_W)) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .adv_i    (adv),
      .mode_i   (cnt_mode_e'(mode_i)),
      .period_i (period_i),
      .count_o  (count_o),
      .down_o   (down_o),
      .wrap_o   (wrap)
   );

   timer_ovf_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wrap),
      .clr_i  (flag_clr_i),
      .flag_o (flag_o)
   );

   assign irq_o        = flag_o & ie_i;
   assign zero_hit_o   = (count_o == '0);
   assign period_hit_o = (count_o == period_i);

   assert_irq_follow_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o && ie_i) |-> irq_o);

   assert_no_tick_wrap_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !flag_o && !flag_clr_i) |=> !flag_o);

endmodule

// File: tb/modal_timer_tb_top.sv
module modal_timer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 6;
   localparam int WMAX       = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic [1:0]   div = 2'b00;
   logic [1:0]   src = 2'b00;
   logic         clr = 1'b0;
   logic [W-1:0] period = '0;
   logic         ext_t = 1'b0, ia_t = 1'b0, ib_t = 1'b0;
   logic         ie = 1'b0;
   logic         fclr = 1'b0;
   logic [W-1:0] count;
   logic         down, phit, zhit, flag, irq;

   int total = 0;
   int bad = 0;
   string tag = "R1";
   logic [15:0] lfsr = 16'hACE1;
   bit   auto_fclr = 1'b0;

   int m_cnt = 0, m_pre = 0;
   bit m_dn = 0, m_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modal_timer #(.CNT_W(W), .DIV_BITS(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .div_i(div), .src_i(src),
      .clr_i(clr), .period_i(period), .ext_tick_i(ext_t), .int_a_tick_i(ia_t),
      .int_b_tick_i(ib_t), .ie_i(ie), .flag_clr_i(fclr), .count_o(count),
      .down_o(down), .period_hit_o(phit), .zero_hit_o(zhit), .flag_o(flag),
      .irq_o(irq)
   );

   // arithmetic model of the requirements, advanced on each rising edge
   always @(posedge clk) begin
      bit s, adv, wr;
      int mask;
      if (!rst_n) begin
         m_cnt = 0; m_pre = 0; m_dn = 0; m_flag = 0;
      end else begin
         case (src)
            2'd0: s = ext_t;
            2'd1: s = ia_t;
            2'd2: s = ib_t;
            default: s = !ext_t;
         endcase
         mask = (1 << div) - 1;
         adv = s && ((m_pre & mask) == mask);
         wr = 0;
         if (clr) begin
            m_cnt = 0; m_dn = 0; m_pre = 0;
         end else begin
            if (s) m_pre = (m_pre + 1) % 8;
            if (adv) begin
               case (mode)
                  2'd1: if (m_cnt >= period) begin m_cnt = 0; wr = 1; end
                        else m_cnt = m_cnt + 1;
                  2'd2: if (m_cnt == WMAX) begin m_cnt = 0; wr = 1; end
                        else m_cnt = m_cnt + 1;
                  2'd3: begin
                     if (!m_dn && m_cnt < period) m_cnt = m_cnt + 1;
                     else if (m_cnt == 0) begin m_dn = 0; wr = 1; end
                     else begin
                        m_cnt = m_cnt - 1;
                        if (m_cnt == 0) begin m_dn = 0; wr = 1; end
                        else m_dn = 1;
                     end
                  end
                  default: ;
               endcase
            end
         end
         if (wr) m_flag = 1;
         else if (fclr) m_flag = 0;
      end
   end

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic check_all();
      chk({tag, " count"}, int'(count), m_cnt);
      chk({tag, " direction"}, int'(down), int'(m_dn));
      chk("R9 flag", int'(flag), int'(m_flag));
      chk("R10 irq", int'(irq), int'(m_flag && ie));
      chk("R11 zero strobe", int'(zhit), int'(m_cnt == 0));
      chk("R11 period strobe", int'(phit), int'(m_cnt == int'(period)));
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_all();
         clr  = 1'b0;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         ext_t = lfsr[0];
         ia_t  = lfsr[3] | lfsr[8];
         ib_t  = lfsr[5] & lfsr[11];
         fclr  = auto_fclr && (lfsr[7:4] == 4'd0);
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      check_all();
      clr = 1'b1;
      ia_t = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 reset count", int'(count), 0);
      chk("R1 reset direction", int'(down), 0);
      chk("R1 reset flag", int'(flag), 0);
      chk("R1 reset irq", int'(irq), 0);
      rst_n = 1'b1;
      tag = "R1";
      run(2);

      // R6 R7: every source and divider pair in period mode
      mode = 2'b01; period = 6'd5; ie = 1'b1;
      for (int s = 0; s < 4; s++) begin
         for (int d = 0; d < 4; d++) begin
            tag = $sformatf("R6_R7 src%0d div%0d", s, d);
            src = 2'(s); div = 2'(d);
            pulse_clear();
            run(60);
         end
      end

      // R3: every small period in period mode
      src = 2'b01; div = 2'b00;
      for (int p = 0; p < 8; p++) begin
         tag = $sformatf("R3 period%0d", p);
         period = 6'(p);
         pulse_clear();
         run(25);
      end

      // R4: free-running wrap through all ones
      tag = "R4"; mode = 2'b10; period = 6'd20;
      pulse_clear();
      run(220);

      // R5: up/down over every small period, with flag clears racing zero-returns
      mode = 2'b11; auto_fclr = 1'b1;
      for (int p = 0; p < 8; p++) begin
         tag = $sformatf("R5 period%0d", p);
         period = 6'(p);
         pulse_clear();
         run(40);
      end

      // R2: halt holds whatever ticks arrive
      tag = "R2"; mode = 2'b00; src = 2'b01;
      run(30);

      // R8: clear pulses landing on advances mid-count
      tag = "R8"; mode = 2'b11; period = 6'd9;
      run(7);
      pulse_clear();
      run(3);
      pulse_clear();
      run(12);

      // R9 R10: clear flag with irq disabled, then enabled
      tag = "R10"; ie = 1'b0; auto_fclr = 1'b0; mode = 2'b01; period = 6'd3;
      run(20);
      @(negedge clk); check_all(); fclr = 1'b1;
      run(3);
      ie = 1'b1;
      run(20);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule